// File: doc/BRIEF.md
# Atomic Locked Read-Modify-Write Sequencer

This block sits between a core's memory pipeline and a shared single-master bus. It takes a locked read-modify-write request and turns it into an atomic bus sequence. First it waits until the core's counts of outstanding ordinary loads and stores reach zero. Then it raises a bus lock and reads the operand. It combines the operand with the request data using a small replaceable function and writes the result back. It drops the lock only after the last write has been acknowledged. An operand that straddles a bus-word boundary is read in two beats and written in two beats, and the lock stays up across all four.

The request port uses valid/ready handshaking. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high, and `req_ready` is high only while the sequencer is idle. The bus port also uses valid/ready: the sequencer keeps `bus_valid` and every request field steady until the edge where `bus_ready` is high, and read data is taken on that edge. The result outputs `rsp_valid` and `rsp_err` are single-cycle pulses that cannot be back-pressured.

While a locked operation is in flight, a separate gate passes only instruction-fetch and page-walk accesses from the rest of the core. Loads and stores are held back until the sequencer returns to idle.

Top module: `locked_rmw_seq`

## Requirements
- R1: `req_ready` is 1 only in the idle state. After a request is accepted it stays 0 until the cycle after the `rsp_valid` pulse.
- R2: No bus beat is issued and `bus_lock` stays 0 until `pend_loads` and `pend_stores` have both been seen as zero. While either count is nonzero after acceptance, `bus_valid` and `bus_lock` stay 0.
- R3: `bus_lock` is 1 for every beat, and it stays 1 without a gap from the first read beat up to and including the final write acknowledge. It is 0 in the cycle that follows that acknowledge.
- R4: `req_size` encodes the operand length as 0, 1, 2 or 3 for 1, 2, 4 or 8 bytes. Let o be the address byte offset, `req_addr[2:0]`, and n the operand length. When o+n ≤ 8, exactly one read beat and one write beat are issued at `req_addr` with its low 3 bits cleared, and `bus_be` bit i is set for o ≤ i < o+n.
- R5: When o+n > 8, two read beats are issued, lower word first and then the next word (address + 8), followed by two write beats in the same order. The first beat enables bytes o..7 and the second enables bytes 0..o+n-9.
- R6: On completion, `rsp_valid` pulses for exactly one cycle while `bus_lock` is 0. `rsp_old` holds the operand's original memory value, little-endian and zero-extended.
- R7: `req_op` selects the stored value: 0 is old + data modulo 2^(8n), 1 is old AND data, 2 is old OR data, 3 is data (swap). Memory bytes outside the operand are left unchanged.
- R8: A request accepted with `req_to_mem` = 0 yields a one-cycle `rsp_err` pulse in the cycle after acceptance. It produces no bus beat, no lock and no `rsp_valid`.
- R9: `oth_class` encodes 0 for load, 1 for store, 2 for instruction fetch and 3 for page walk. When idle, `oth_grant` equals `oth_valid`. When busy, `oth_grant` is 1 only for classes 2 and 3.
- R10: While `bus_valid` is 1 and `bus_ready` is 0, `bus_valid`, `bus_we`, `bus_addr`, `bus_be` and `bus_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Locked request offered |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand length code (1/2/4/8 bytes) |
| req_op | input | 2 | Modify function code |
| req_data | input | DATA_W | Source operand |
| req_to_mem | input | 1 | Destination is memory |
| rsp_valid | output | 1 | Completion pulse |
| rsp_err | output | 1 | Invalid-operation pulse |
| rsp_old | output | DATA_W | Original operand value |
| pend_loads | input | CNT_W | Outstanding ordinary loads |
| pend_stores | input | CNT_W | Outstanding ordinary stores |
| oth_valid | input | 1 | Other core access requested |
| oth_class | input | 2 | Class of the other access |
| oth_grant | output | 1 | Other access may issue |
| bus_valid | output | 1 | Bus beat requested |
| bus_ready | input | 1 | Bus beat accepted |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | ADDR_W | Bus-word aligned address |
| bus_be | output | DATA_W/8 | Byte enables |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with bus_ready |
| bus_lock | output | 1 | Bus lock held |

## Verification
A wrong sequencer state shows up at the ports within one bus beat. If the lock drops early, the monitor sees `bus_lock` low while a write is still owed, in that same cycle. A lost split shows up as a beat count or byte-enable mismatch on the first beat. A wrong lane shift or modify function leaves memory bytes and `rsp_old` mismatched when `rsp_valid` pulses, a few cycles later. The bench sweeps every byte offset, length and function, with and without bus wait states and pending-counter stalls. It compares the whole memory image after each operation, so a stray byte enable is caught on the operation that caused it.

// File: rtl/lrmw_pkg.sv
package lrmw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DRAIN, S_READ, S_MODIFY, S_WRITE, S_UNLOCK
  } seq_state_t;

  typedef enum logic [1:0] {OP_ADD, OP_AND, OP_OR, OP_SWAP} rmw_op_t;

  typedef enum logic [1:0] {AC_LOAD, AC_STORE, AC_FETCH, AC_WALK} acc_class_t;
endpackage

// File: rtl/lrmw_lane_map.sv
module lrmw_lane_map #(
  parameter int DATA_W = 64
) (
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [1:0]                  size,
  input  logic [DATA_W-1:0]           rd_lo,
  input  logic [DATA_W-1:0]           rd_hi,
  input  logic [DATA_W-1:0]           new_val,
  output logic [DATA_W/8-1:0]         be_lo,
  output logic [DATA_W/8-1:0]         be_hi,
  output logic                        split,
  output logic [DATA_W-1:0]           size_mask,
  output logic [DATA_W-1:0]           old_val,
  output logic [DATA_W-1:0]           wr_lo,
  output logic [DATA_W-1:0]           wr_hi
);
  localparam int NB   = DATA_W / 8;
  localparam int SH_W = $clog2(DATA_W) + 1;

  logic [2*NB-1:0]     span;
  logic [SH_W-1:0]     shamt;
  logic [2*DATA_W-1:0] wwin;

  // byte lanes touched across two consecutive bus words
  always_comb begin
    int nbytes;
    nbytes = 1 << size;
    for (int i = 0; i < 2*NB; i++)
      span[i] = (i >= int'(off)) && (i < int'(off) + nbytes);
    for (int b = 0; b < NB; b++)
      size_mask[b*8 +: 8] = (b < nbytes) ? 8'hFF : 8'h00;
  end

  assign shamt   = SH_W'({off, 3'b000});
  assign old_val = DATA_W'({rd_hi, rd_lo} >> shamt) & size_mask;
  assign wwin    = {{DATA_W{1'b0}}, new_val & size_mask} << shamt;
  assign wr_lo   = wwin[DATA_W-1:0];
  assign wr_hi   = wwin[2*DATA_W-1:DATA_W];
  assign be_lo   = span[NB-1:0];
  assign be_hi   = span[2*NB-1:NB];
  assign split   = |be_hi;
endmodule

// File: rtl/lrmw_alu.sv
module lrmw_alu
  import lrmw_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  rmw_op_t           op,
  input  logic [DATA_W-1:0] size_mask,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] new_val
);
  logic [DATA_W-1:0] raw;

  always_comb begin
    unique case (op)
      OP_ADD:  raw = old_val + operand;
      OP_AND:  raw = old_val & operand;
      OP_OR:   raw = old_val | operand;
      default: raw = operand;
    endcase
  end

  assign new_val = raw & size_mask;
endmodule

// File: rtl/lrmw_access_gate.sv
module lrmw_access_gate
  import lrmw_pkg::*;
(
  input  logic       busy,
  input  logic       oth_valid,
  input  logic [1:0] oth_class,
  output logic       oth_grant
);
  logic exempt;

  assign exempt    = (acc_class_t'(oth_class) == AC_FETCH) ||
                     (acc_class_t'(oth_class) == AC_WALK);
  assign oth_grant = oth_valid && (!busy || exempt);
endmodule

// File: rtl/locked_rmw_seq.sv
module locked_rmw_seq
  import lrmw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic [1:0]          req_op,
  input  logic [DATA_W-1:0]   req_data,
  input  logic                req_to_mem,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [DATA_W-1:0]   rsp_old,
  input  logic [CNT_W-1:0]    pend_loads,
  input  logic [CNT_W-1:0]    pend_stores,
  input  logic                oth_valid,
  input  logic [1:0]          oth_class,
  output logic                oth_grant,
  output logic                bus_valid,
  input  logic                bus_ready,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_lock
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  seq_state_t        state;
  logic [ADDR_W-1:0] word_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  rmw_op_t           op_q;
  logic [DATA_W-1:0] opnd_q, rd_lo_q, rd_hi_q, wr_lo_q, wr_hi_q, old_q;
  logic              beat_q, err_q;

  logic [NB-1:0]     be_lo, be_hi;
  logic              split;
  logic [DATA_W-1:0] size_mask, old_val, new_val, wr_lo, wr_hi;
  logic              drained, beat_done, last_beat;

  lrmw_lane_map #(.DATA_W(DATA_W)) u_lanes (
    .off(off_q), .size(size_q), .rd_lo(rd_lo_q), .rd_hi(rd_hi_q),
    .new_val(new_val), .be_lo(be_lo), .be_hi(be_hi), .split(split),
    .size_mask(size_mask), .old_val(old_val), .wr_lo(wr_lo), .wr_hi(wr_hi)
  );

  lrmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op_q), .size_mask(size_mask), .old_val(old_val),
    .operand(opnd_q), .new_val(new_val)
  );

  lrmw_access_gate u_gate (
    .busy(state != S_IDLE), .oth_valid(oth_valid),
    .oth_class(oth_class), .oth_grant(oth_grant)
  );

  assign drained   = (pend_loads == '0) && (pend_stores == '0);
  assign beat_done = bus_valid && bus_ready;
  assign last_beat = !split || beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      word_q  <= '0;
      off_q   <= '0;
      size_q  <= '0;
      op_q    <= OP_ADD;
      opnd_q  <= '0;
      rd_lo_q <= '0;
      rd_hi_q <= '0;
      wr_lo_q <= '0;
      wr_hi_q <= '0;
      old_q   <= '0;
      beat_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          if (req_to_mem) begin
            word_q  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            off_q   <= req_addr[OFF_W-1:0];
            size_q  <= req_size;
            op_q    <= rmw_op_t'(req_op);
            opnd_q  <= req_data;
            rd_hi_q <= '0;
            beat_q  <= 1'b0;
            state   <= S_DRAIN;
          end else begin
            err_q <= 1'b1;
          end
        end
        S_DRAIN: if (drained) state <= S_READ;
        S_READ: if (beat_done) begin
          if (beat_q) rd_hi_q <= bus_rdata;
          else        rd_lo_q <= bus_rdata;
          if (last_beat) begin
            beat_q <= 1'b0;
            state  <= S_MODIFY;
          end else begin
            beat_q <= 1'b1;
          end
        end
        S_MODIFY: begin
          old_q   <= old_val;
          wr_lo_q <= wr_lo;
          wr_hi_q <= wr_hi;
          state   <= S_WRITE;
        end
        S_WRITE: if (beat_done) begin
          if (last_beat) begin
            beat_q <= 1'b0;
            state  <= S_UNLOCK;
          end else begin
            beat_q <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_UNLOCK);
  assign rsp_err   = err_q;
  assign rsp_old   = old_q;
  assign bus_valid = (state == S_READ) || (state == S_WRITE);
  assign bus_we    = (state == S_WRITE);
  assign bus_lock  = (state == S_READ) || (state == S_MODIFY) || (state == S_WRITE);
  assign bus_addr  = word_q + (beat_q ? ADDR_W'(NB) : ADDR_W'(0));
  assign bus_be    = beat_q ? be_hi : be_lo;
  assign bus_wdata = beat_q ? wr_hi_q : wr_lo_q;

  // R3: every beat travels under the lock
  assert_lock_on_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_lock);

  // R2: the lock only rises after the pending counters were seen empty
  assert_drained_before_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> $past(pend_loads == '0 && pend_stores == '0));

  // R10: a stalled beat holds its request fields
  assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_we) && $stable(bus_addr)
      && $stable(bus_be) && $stable(bus_wdata));

  // R9: under the lock only fetch and page-walk accesses are granted
  assert_gate_while_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock && oth_grant |-> oth_class[1]);

  // R6: completion follows the lock release and lasts one cycle
  assert_done_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_lock && $past(bus_lock));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: a rejected request stays off the bus
  assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !bus_valid && !bus_lock && !rsp_valid);

  // R4: a beat always enables at least one byte
  assert_be_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_be != '0);
endmodule

// File: tb/locked_rmw_seq_test.sv
module locked_rmw_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [1:0]  req_op = '0;
  logic [63:0] req_data = '0;
  logic        req_to_mem = 1'b1;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_old;
  logic [3:0]  pend_loads = '0, pend_stores = '0;
  logic        oth_valid = 1'b0;
  logic [1:0]  oth_class = '0;
  logic        oth_grant;
  logic        bus_valid, bus_we, bus_lock;
  logic        bus_ready = 1'b0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_be;
  logic [63:0] bus_wdata, bus_rdata;

  locked_rmw_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_op(req_op), .req_data(req_data),
    .req_to_mem(req_to_mem), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_old(rsp_old),
    .pend_loads(pend_loads), .pend_stores(pend_stores), .oth_valid(oth_valid),
    .oth_class(oth_class), .oth_grant(oth_grant), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_lock(bus_lock)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  logic stall_mode = 1'b0;

  // bus memory model
  always_comb
    for (int b = 0; b < 8; b++) bus_rdata[b*8 +: 8] = mem[{bus_addr[5:3], 3'(b)}];

  always @(posedge clk) begin
    #1;
    bus_ready = stall_mode ? ~bus_ready : 1'b1;
  end

  // monitor
  int rd_cnt, wr_cnt, exp_beats, lock_gap, hold_err;
  logic seen_valid;
  logic [7:0] first_be, second_be;
  logic [15:0] first_addr, second_addr;
  logic stalled;
  logic [15:0] st_addr;
  logic [7:0] st_be;
  logic [63:0] st_wd;
  logic st_we;
  initial begin
    rd_cnt = 0; wr_cnt = 0; exp_beats = 0; lock_gap = 0; hold_err = 0;
    seen_valid = 0; stalled = 0;
  end

  always @(negedge clk) if (rst_n) begin
    if (stalled && !(bus_valid && bus_addr == st_addr && bus_be == st_be &&
                     bus_wdata == st_wd && bus_we == st_we)) hold_err++;
    stalled = bus_valid && !bus_ready;
    st_addr = bus_addr; st_be = bus_be; st_wd = bus_wdata; st_we = bus_we;
    if (bus_valid) seen_valid = 1;
    if (seen_valid && wr_cnt < exp_beats && !bus_lock) lock_gap++;
    if (bus_valid && !bus_lock) lock_gap++;
    if (bus_valid && bus_ready) begin
      if (!bus_we) begin
        if (rd_cnt == 0) begin first_be = bus_be; first_addr = bus_addr; end
        else begin second_be = bus_be; second_addr = bus_addr; end
        rd_cnt++;
      end else begin
        for (int b = 0; b < 8; b++)
          if (bus_be[b]) mem[{bus_addr[5:3], 3'(b)}] = bus_wdata[b*8 +: 8];
        wr_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] alu(input int op, input logic [63:0] a, input logic [63:0] d, input int n);
    logic [63:0] r, m;
    m = (n == 8) ? '1 : ((64'd1 << (8*n)) - 1);
    case (op)
      0: r = a + d;
      1: r = a & d;
      2: r = a | d;
      default: r = d;
    endcase
    return r & m;
  endfunction

  task automatic run_op(input int addr, input int sz, input int op, input logic [63:0] d, input int hold);
    int n, off, waitc;
    logic [63:0] eo, en;
    bit mem_ok;
    n = 1 << sz; off = addr % 8;
    eo = '0;
    for (int i = 0; i < n; i++) eo[i*8 +: 8] = mem[(addr + i) % 64];
    en = alu(op, eo, d, n);
    for (int i = 0; i < 64; i++) exp_mem[i] = mem[i];
    for (int i = 0; i < n; i++) exp_mem[(addr + i) % 64] = en[i*8 +: 8];
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; seen_valid = 0; lock_gap = 0;
    exp_beats = (off + n > 8) ? 2 : 1;
    chk(req_ready == 1'b1, "R1 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1; req_addr = 16'(addr); req_size = 2'(sz); req_op = 2'(op);
    req_data = d; req_to_mem = 1;
    pend_loads = (hold > 0) ? 4'd2 : 4'd0;
    pend_stores = (hold > 1) ? 4'd1 : 4'd0;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R1 ready low while busy", 64'(req_ready), 64'd0);
    for (int h = 0; h < hold; h++) begin
      chk(!bus_valid && !bus_lock, "R2 no beat before drain", {bus_valid, bus_lock}, 64'd0);
      oth_valid = 1; oth_class = 2'(h % 4);
      #1;
      chk(oth_grant == (h % 4 >= 2), "R9 gate while busy", 64'(oth_grant), 64'(h % 4 >= 2));
      @(negedge clk);
      if (h == hold - 1) begin pend_loads = 0; pend_stores = 0; end
    end
    oth_valid = 0;
    waitc = 0;
    while (!rsp_valid && waitc < 100) begin
      if (bus_lock) begin
        oth_valid = 1; oth_class = 2'(waitc % 4);
        #1;
        chk(oth_grant == (waitc % 4 >= 2), "R9 gate while locked", 64'(oth_grant), 64'(waitc % 4 >= 2));
        oth_valid = 0;
      end
      @(negedge clk); waitc++;
    end
    chk(rsp_valid == 1'b1, "R6 completion seen", 64'(rsp_valid), 64'd1);
    chk(!bus_lock, "R3 lock released at completion", 64'(bus_lock), 64'd0);
    chk(rsp_old == eo, "R6 old value", rsp_old, eo);
    chk(lock_gap == 0, "R3 lock held across beats", 64'(lock_gap), 64'd0);
    chk(rd_cnt == exp_beats && wr_cnt == exp_beats, exp_beats == 2 ? "R5 beat count" : "R4 beat count",
        64'(rd_cnt * 16 + wr_cnt), 64'(exp_beats * 17));
    chk(first_addr == 16'(addr & ~7), "R4 first beat address", 64'(first_addr), 64'(addr & ~7));
    chk(first_be == 8'((((1 << n) - 1) << off) & 8'hFF), "R4 first beat enables",
        64'(first_be), 64'((((1 << n) - 1) << off) & 8'hFF));
    if (exp_beats == 2) begin
      chk(second_addr == 16'((addr & ~7) + 8), "R5 second beat address", 64'(second_addr), 64'((addr & ~7) + 8));
      chk(second_be == 8'(((1 << n) - 1) >> (8 - off)), "R5 second beat enables",
          64'(second_be), 64'(((1 << n) - 1) >> (8 - off)));
    end
    mem_ok = 1;
    for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) mem_ok = 0;
    chk(mem_ok, "R7 memory image after modify", 64'(op), en);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R6 single completion pulse", 64'(rsp_valid), 64'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int k;
    bit ok;
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !bus_valid && !bus_lock && !rsp_valid && !rsp_err, "R1 reset state",
        {req_ready, bus_valid, bus_lock, rsp_valid, rsp_err}, 64'h10);
    // R9 idle: every class granted, nothing without valid
    for (int c = 0; c < 4; c++) begin
      oth_valid = 1; oth_class = 2'(c); #1;
      chk(oth_grant == 1'b1, "R9 idle grant", 64'(oth_grant), 64'd1);
      oth_valid = 0; #1;
      chk(oth_grant == 1'b0, "R9 idle no valid", 64'(oth_grant), 64'd0);
    end
    // R8 non-memory destination
    for (int i = 0; i < 64; i++) exp_mem[i] = mem[i];
    @(negedge clk);
    req_valid = 1; req_to_mem = 0; req_addr = 16'h0013; req_size = 2; req_op = 0;
    @(negedge clk);
    req_valid = 0; req_to_mem = 1;
    chk(rsp_err && !bus_valid && !bus_lock, "R8 error pulse", {rsp_err, bus_valid, bus_lock}, 64'h4);
    @(negedge clk);
    chk(!rsp_err && !bus_valid && !rsp_valid && req_ready, "R8 pulse ends quietly",
        {rsp_err, bus_valid, rsp_valid}, 64'd0);
    ok = 1;
    for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) ok = 0;
    chk(ok, "R8 memory untouched", 64'(ok), 64'd1);
    // sweep: all offsets x sizes x ops
    k = 0;
    for (int off = 0; off < 8; off++)
      for (int sz = 0; sz < 4; sz++)
        for (int op = 0; op < 4; op++) begin
          stall_mode = k[0] ^ k[3];
          run_op(8 * (k % 6) + off, sz, op,
                 64'h0123_4567_89AB_CDEF ^ (64'(k) * 64'h9E37_79B9_7F4A_7C15),
                 (k % 5 == 0) ? 3 : ((k % 7 == 0) ? 1 : 0));
          k++;
        end
    chk(hold_err == 0, "R10 stalled request held", 64'(hold_err), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule